// File: doc/BRIEF.md
# I2C Target with 512-Byte Memory

This block is a target (slave) on a two-wire I2C bus that gives a bus master byte access to a 512-byte on-chip memory. SCL and SDA arrive as samples already synchronized to the system clock. The block pulls SDA low through a single output-enable and never drives it high. It finds START, repeated START and STOP on the bus. It answers one 7-bit target address. The lowest bit of that 7-bit address is not used for matching; it supplies bit 8 of the memory address instead.

A master writes by sending the target address, then a word-address byte that loads the low eight bits of an internal address latch, then any number of data bytes. These bytes go to consecutive locations. A read sent with no word address is a current-address read. It starts where the last access left off and steps forward one location for every byte. A random read is a write header and word address, then a repeated START and a read header. The latch keeps its value across transactions and across START and STOP. It rolls over from the last location to location zero.

Top module: `i2c_mem_target`

## Requirements
- R1: A header byte whose bits [7:2] equal 6'b101000 is acknowledged: SDA is held low for the whole 9th SCL high period. Bit 0 of the header is the direction: 1 reads and 0 writes.
- R2: A header whose bits [7:2] differ is never acknowledged. The block does not drive SDA, and it ignores every later byte until the next START. No memory location and no latch bit changes.
- R3: In a write, the word-address byte and every data byte are acknowledged. The word-address byte loads address bits [7:0].
- R4: Successive data bytes in one write are stored at successive addresses, and the address advances by one after each stored byte.
- R5: Header bit 1 becomes memory address bit 8 for the transaction it starts, in both directions.
- R6: A read started without a word address returns the byte at {header bit 1, latched bits [7:0]}. The latch already points one past the last location written or read.
- R7: Read data is placed on SDA while SCL is low, most significant bit first. Each master acknowledge makes the block send the byte at the next address.
- R8: Stepping past address 0x1FF gives 0x000, for reads and for writes alike.
- R9: Each of these four endings leaves SDA released, and the next read continues at the following address: a master no-acknowledge then STOP; a no-acknowledge then START; STOP in place of the 9th clock; START in place of the 9th clock.
- R10: A write header and word address followed by a repeated START store nothing. A read header that follows reads from the newly loaded address.
- R11: After reset SDA is released. A START or STOP at any point releases SDA and restarts header decoding, and a byte cut short stores nothing. The address latch keeps its value.
- R12: The block only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level as seen on the wire |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it forms a START or STOP. They also assume that each SCL level lasts at least a few system clocks, so that the registered output and the one-cycle read latency of the memory settle before the next edge. The bench drives the bus with a fixed number of clocks per SCL phase. It applies every data change while SCL is low and always steps it apart from the SCL edge. SDA is modelled as the wired AND of the master's level and the block's pull-down.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_HDR_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_tgt_ram.sv
module i2c_tgt_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int         MEM_AW = 9,
  parameter logic [6:0] DEV_ID = 7'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [7:0]        rd_data,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic [MEM_AW-1:0] cur_addr,
  output logic              sda_oe
);
  localparam int PAGE_W = MEM_AW - 8;

  tgt_state_e  state;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg;
  logic        rd_dir;
  logic        m_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      rd_dir    <= 1'b0;
      m_ack     <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      cur_addr  <= '0;
      sda_oe    <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (start_ev) begin
        state   <= ST_HDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_ev) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          ST_HDR, ST_WADDR, ST_WDATA: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_i};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (state == ST_HDR) begin
                if (shreg[7:PAGE_W+1] == DEV_ID[6:PAGE_W]) begin
                  sda_oe   <= 1'b1;
                  rd_dir   <= shreg[0];
                  cur_addr[MEM_AW-1:8] <= shreg[PAGE_W:1];
                  state    <= ST_HDR_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_WADDR) begin
                cur_addr[7:0] <= shreg;
                sda_oe        <= 1'b1;
                state         <= ST_WADDR_ACK;
              end else begin
                mem_we    <= 1'b1;
                mem_wdata <= shreg;
                sda_oe    <= 1'b1;
                state     <= ST_WDATA_ACK;
              end
            end
          end
          ST_HDR_ACK: begin
            if (scl_fall) begin
              if (rd_dir) begin
                shreg   <= rd_data;
                sda_oe  <= ~rd_data[7];
                bit_cnt <= 4'd1;
                state   <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WADDR;
              end
            end
          end
          ST_WADDR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (mem_we) cur_addr <= cur_addr + 1'b1;
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe   <= 1'b0;
                cur_addr <= cur_addr + 1'b1;
                state    <= ST_RACK;
              end else begin
                shreg   <= {shreg[6:0], 1'b0};
                sda_oe  <= ~shreg[6];
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) m_ack <= ~sda_i;
            if (scl_fall) begin
              if (m_ack) begin
                shreg   <= rd_data;
                sda_oe  <= ~rd_data[7];
                bit_cnt <= 4'd1;
                state   <= ST_RDATA;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int         MEM_AW = 9,
  parameter logic [6:0] DEV_ID = 7'h50
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic mem_we;
  logic [7:0] mem_wdata, rd_data;
  logic [MEM_AW-1:0] cur_addr;

  i2c_bus_events i_events (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_tgt_fsm #(.MEM_AW(MEM_AW), .DEV_ID(DEV_ID)) i_fsm (
    .clk       (clk),
    .rst       (rst),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .rd_data   (rd_data),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .cur_addr  (cur_addr),
    .sda_oe    (sda_oe)
  );

  i2c_tgt_ram #(.AW(MEM_AW), .DW(8)) i_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (cur_addr),
    .wdata (mem_wdata),
    .raddr (cur_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk #(
  parameter int MEM_AW = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              mem_we,
  input logic [MEM_AW-1:0] cur_addr
);
  // R11: a START frees the data line on the next cycle
  a_r11_start_release: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !sda_oe);

  // R11: a STOP frees the data line on the next cycle
  a_r11_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_oe);

  // R4 and R8: every stored byte moves the latch on by one, modulo the memory size
  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> cur_addr == MEM_AW'($past(cur_addr) + 1'b1));

  // R12: the pull-down only switches on while SCL is low
  a_r12_drive_low_phase: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  // R3: a store happens only in the SCL-low phase after a full byte
  a_r3_store_scl_low: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !scl_i);
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.MEM_AW(MEM_AW)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .mem_we   (mem_we),
  .cur_addr (cur_addr)
);

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_mem_target i_i2c_mem_target (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  int checks = 0;
  int failures = 0;
  bit reported = 1'b0;

  logic [7:0] exp_mem [512];
  logic [8:0] ptr;

  // bus monitors: R12 phase rule and R2 silence window
  logic prev_oe = 1'b0;
  int   phase_viol = 0;
  bit   watch_oe = 1'b0;
  bit   oe_seen = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (sda_oe && !prev_oe && scl_m) phase_viol++;
      if (watch_oe && sda_oe) oe_seen = 1'b1;
      prev_oe = sda_oe;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) + ((a >> 8) * 91) + 5);
  endfunction

  function automatic logic [7:0] hdr(input logic page, input logic rd);
    return {6'b101000, page, rd};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hold();
      scl_m = 1'b1; hold();
      scl_m = 1'b0;
    end
    hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    sda_m = 1'b1;
    scl_m = 1'b1; hold();
    acked = ~sda_line;
    scl_m = 1'b0; hold();
  endtask

  task automatic recv8(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold();
      scl_m = 1'b1; hold();
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    hold();
  endtask

  task automatic ack9(input logic give_ack);
    sda_m = ~give_ack; hold();
    scl_m = 1'b1; hold();
    scl_m = 1'b0; hold();
    sda_m = 1'b1;
  endtask

  // one-byte random read ending in NACK and STOP
  task automatic rand_read1(input logic [8:0] a, output logic [7:0] b);
    logic k;
    bus_start();
    send_byte(hdr(a[8], 1'b0), k);
    send_byte(a[7:0], k);
    bus_rstart();
    send_byte(hdr(a[8], 1'b1), k);
    recv8(b);
    ack9(1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!reported) begin
      reported = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end

  initial begin
    logic k;
    logic [7:0] got;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    hold();
    chk("R11 reset releases SDA", sda_oe, 0);

    // sweep write of the whole array in one transaction
    bus_start();
    send_byte(hdr(1'b0, 1'b0), k);  chk("R1 header ack", k, 1);
    send_byte(8'h00, k);            chk("R3 word address ack", k, 1);
    for (int a = 0; a < 512; a++) begin
      send_byte(pat(a), k);
      exp_mem[a] = pat(a);
      if (a < 4 || a == 511) chk("R3 data ack", k, 1);
    end
    bus_stop();
    ptr = 9'h000;

    // sweep current-address read, one byte past the end
    bus_start();
    send_byte(hdr(1'b0, 1'b1), k);  chk("R1 read header ack", k, 1);
    for (int i = 0; i <= 512; i++) begin
      recv8(got);
      ack9(i != 512);
      if (i == 512) chk("R8 read wrap to 0x000", got, exp_mem[0]);
      else chk("R7/R4 sequential byte", got, exp_mem[i]);
    end
    bus_stop();
    chk("R9 NACK+STOP releases SDA", sda_oe, 0);
    ptr = 9'h001;

    // write wrap across 0x1FF
    bus_start();
    send_byte(hdr(1'b1, 1'b0), k);
    send_byte(8'hFF, k);
    send_byte(8'hC3, k);
    send_byte(8'h3C, k);
    bus_stop();
    exp_mem[9'h1FF] = 8'hC3; exp_mem[0] = 8'h3C;
    bus_start();
    send_byte(hdr(1'b1, 1'b0), k);
    send_byte(8'hFF, k);
    bus_rstart();
    send_byte(hdr(1'b1, 1'b1), k);
    recv8(got); ack9(1'b1); chk("R8 byte at 0x1FF", got, 8'hC3);
    recv8(got); ack9(1'b0); chk("R8 write wrapped into 0x000", got, 8'h3C);
    bus_stop();

    // page bit selects the upper half
    bus_start();
    send_byte(hdr(1'b1, 1'b0), k);
    send_byte(8'h10, k);
    send_byte(8'h5A, k);
    bus_stop();
    exp_mem[9'h110] = 8'h5A;
    rand_read1(9'h010, got); chk("R5 lower page untouched", got, exp_mem[9'h010]);
    rand_read1(9'h110, got); chk("R5 upper page written", got, 8'h5A);
    ptr = 9'h111;

    // current-address reads, page taken from each header
    bus_start();
    send_byte(hdr(1'b1, 1'b1), k);
    recv8(got); ack9(1'b0); bus_stop();
    chk("R6 current read page 1", got, exp_mem[9'h111]);
    bus_start();
    send_byte(hdr(1'b0, 1'b1), k);
    recv8(got); ack9(1'b0); bus_stop();
    chk("R6 current read page 0", got, exp_mem[9'h012]);

    // repeated START cancels a write after the word address
    bus_start();
    send_byte(hdr(1'b0, 1'b0), k);
    send_byte(8'h40, k);
    bus_rstart();
    send_byte(hdr(1'b0, 1'b1), k);
    recv8(got); ack9(1'b0); bus_stop();
    chk("R10 read after restart", got, exp_mem[9'h040]);

    // foreign address: silence and no state change
    watch_oe = 1'b1;
    bus_start();
    send_byte(8'hB2, k); chk("R2 foreign write header not acked", k, 0);
    send_byte(8'h77, k); chk("R2 following byte not acked", k, 0);
    send_byte(8'h99, k);
    bus_stop();
    bus_start();
    send_byte(8'h51, k); chk("R2 foreign read header not acked", k, 0);
    recv8(got);
    ack9(1'b1);
    bus_stop();
    watch_oe = 1'b0;
    chk("R2 SDA never driven", oe_seen, 0);
    bus_start();
    send_byte(hdr(1'b0, 1'b1), k);
    recv8(got); ack9(1'b0); bus_stop();
    chk("R2 latch and memory unchanged", got, exp_mem[9'h041]);

    // NACK then START
    bus_start();
    send_byte(hdr(1'b0, 1'b1), k);
    recv8(got); ack9(1'b0);
    chk("R9 byte before NACK+START", got, exp_mem[9'h042]);
    bus_rstart();
    chk("R9 NACK+START releases SDA", sda_oe, 0);
    send_byte(hdr(1'b0, 1'b1), k);
    recv8(got); ack9(1'b0); bus_stop();
    chk("R9 continue after NACK+START", got, exp_mem[9'h043]);

    // STOP in place of the 9th clock
    bus_start();
    send_byte(hdr(1'b0, 1'b1), k);
    recv8(got);
    chk("R9 byte before early STOP", got, exp_mem[9'h044]);
    bus_stop();
    chk("R9 early STOP releases SDA", sda_oe, 0);
    bus_start();
    send_byte(hdr(1'b0, 1'b1), k);
    recv8(got); ack9(1'b0); bus_stop();
    chk("R9 continue after early STOP", got, exp_mem[9'h045]);

    // START in place of the 9th clock
    bus_start();
    send_byte(hdr(1'b0, 1'b1), k);
    recv8(got);
    bus_rstart();
    chk("R9 early START releases SDA", sda_oe, 0);
    send_byte(hdr(1'b0, 1'b1), k);
    recv8(got); ack9(1'b0); bus_stop();
    chk("R9 continue after early START", got, exp_mem[9'h047]);

    // STOP in the middle of a data byte stores nothing
    bus_start();
    send_byte(hdr(1'b0, 1'b0), k);
    send_byte(8'h50, k);
    send_bits(8'h0F, 4);
    bus_stop();
    chk("R11 SDA free after mid-byte STOP", sda_oe, 0);
    rand_read1(9'h050, got);
    chk("R11 cut byte not stored", got, exp_mem[9'h050]);

    chk("R12 pull-down starts only with SCL low", phase_viol, 0);

    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end
endmodule